// File: doc/BRIEF.md
# Grouped Interrupt Aggregator with Critical Fast Path

This block gathers 128 single-bit interrupt requests into one pending image organised as four words of 32 bits. Each source is fixed at build time as either level-sensitive (a sticky condition the source holds) or edge-sensitive (a single-cycle event pulse). Pending state is rolled up into two registered outputs: a summary line for ordinary sources and a separate fast-path line for the sources flagged as critical, so firmware can respond to the urgent events without walking per-group status first.

A small word-addressed register port exposes, per group, the pending word, a write-1-to-clear word for edge pendings, a delivery mask and a second mask kept for the message-based delivery path. A fixed set of sources has no mask plumbing at all: their mask bits read as zero, ignore writes, and always reach the summary.

Top module: `irq_apex_agg`

## Requirements
- R1: Input `irq_in[i]` appears in the pending word of group `i>>5` at bit `i&31`; no bit of the pending image is reserved.
- R2: A level pending bit equals the input value registered two clocks earlier; writing 1 to it through the clear word has no effect.
- R3: An edge pending bit sets on a rising edge of its input, stays set after the input falls, and clears when software writes 1 to that bit through the clear word.
- R4: When a new rising edge and a clear of the same bit fall in the same cycle, the pending bit stays set.
- R5: `summary_irq` is the registered OR of all pending non-critical bits whose delivery-mask bit is 0 (1 means masked); critical sources never drive it.
- R6: `crit_irq` is the registered OR of all pending critical bits whose delivery-mask bit is 0.
- R7: After reset every delivery-mask and message-mask bit is 1, except on the no-mask sources, whose mask bits read 0, ignore writes and never block the summary. Default no-mask sources are inputs 50 to 63; default critical sources are inputs 64 to 95; default edge sources are inputs 104 to 127.
- R8: `addr[3:2]` selects the word kind (0 pending, read-only; 1 clear, write-1, reads 0; 2 delivery mask; 3 message mask) and `addr[1:0]` selects the group; `rdata` holds the selected word one clock after `rd_en`, and writes to the pending word are ignored.
- R9: An output changes one clock after the pending bit that causes it, i.e. three clocks after a level input is driven.
- R10: After reset the pending image is zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 128 | Interrupt request inputs |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Word address: kind in bits 3:2, group in bits 1:0 |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one clock after `rd_en` |
| summary_irq | output | 1 | Rolled-up non-critical interrupt |
| crit_irq | output | 1 | Fast-path critical interrupt |

## Verification
On every cycle the assertions check that level pending bits track the delayed inputs, that edge pendings only drop when a clear hits them, that each output is backed by an unmasked pending bit of the right class, that masks come out of reset in the masked state and that the clear word reads as zero. The scenarios are needed to show the group-to-bit mapping, the exact output latency, the pulse-plus-clear collision, the effect of mask writes and the behaviour of the no-mask sources, since those depend on chosen stimulus sequences and readback values.

// File: rtl/irq_apex_pkg.sv
// Shared types and default configuration for the grouped interrupt aggregator.
// Assumes the default build of four groups of 32 sources.
package irq_apex_pkg;

    typedef enum logic [1:0] {
        KIND_PEND = 2'd0,
        KIND_CLR  = 2'd1,
        KIND_DMSK = 2'd2,
        KIND_MMSK = 2'd3
    } reg_kind_e;

    localparam int DEF_GROUPS = 4;
    localparam int DEF_GW     = 32;

    // Edge sources: inputs 104..127
    localparam logic [127:0] DEF_EDGE_CFG   = 128'hFFFFFF00_00000000_00000000_00000000;
    // Critical sources: inputs 64..95
    localparam logic [127:0] DEF_CRIT_CFG   = 128'h00000000_FFFFFFFF_00000000_00000000;
    // Sources without mask plumbing: inputs 50..63
    localparam logic [127:0] DEF_NOMASK_CFG = 128'h00000000_00000000_FFFC0000_00000000;

endpackage

// File: rtl/irq_grp_latch.sv
// One group of pending bits. Registers the raw inputs once, detects rising
// edges for edge-configured bits and keeps a pending bit per source.
// Assumes inputs are synchronous to clk.
module irq_grp_latch #(
    parameter int              GW       = 32,
    parameter logic [GW-1:0]   EDGE_CFG = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [GW-1:0] src,
    input  logic [GW-1:0] clr,
    output logic [GW-1:0] pend
);

    logic [GW-1:0] src_q;
    logic [GW-1:0] src_qq;
    logic [GW-1:0] rise;

    // Input capture and one-cycle history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            src_qq <= '0;
        end else begin
            src_q  <= src;
            src_qq <= src_q;
        end
    end

    // Rising edge of the captured inputs
    always_comb rise = src_q & ~src_qq;

    // Per-bit pending state, mode picked by configuration
    for (genvar b = 0; b < GW; b++) begin : g_bit
        if (EDGE_CFG[b]) begin : g_edge
            // Edge bit: a new rise wins over a clear
            always_ff @(posedge clk) begin
                if (!rst_n) pend[b] <= 1'b0;
                else        pend[b] <= rise[b] | (pend[b] & ~clr[b]);
            end
        end else begin : g_level
            // Level bit: follows the captured input
            always_ff @(posedge clk) begin
                if (!rst_n) pend[b] <= 1'b0;
                else        pend[b] <= src_q[b];
            end
        end
    end

endmodule

// File: rtl/irq_reg_port.sv
// Register port: per-group mask storage, clear strobes and registered readback.
// Assumes addr = {kind, group}; masks reset to 1 except on no-mask sources.
module irq_reg_port
    import irq_apex_pkg::*;
#(
    parameter int                     GROUPS     = 4,
    parameter int                     GW         = 32,
    parameter logic [GROUPS*GW-1:0]   NOMASK_CFG = '0,
    localparam int                    NSRC       = GROUPS * GW,
    localparam int                    GSEL_W     = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int                    AW         = GSEL_W + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [AW-1:0]   addr,
    input  logic [GW-1:0]   wdata,
    input  logic [NSRC-1:0] pend,
    output logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] dmask,
    output logic [NSRC-1:0] mmask,
    output logic [GW-1:0]   rdata
);

    reg_kind_e         kind;
    logic [GSEL_W-1:0] grp;

    // Address split
    always_comb begin
        kind = reg_kind_e'(addr[AW-1 -: 2]);
        grp  = addr[GSEL_W-1:0];
    end

    // Clear strobes for the addressed group
    always_comb begin
        clr = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if (wr_en && kind == KIND_CLR && grp == GSEL_W'(g))
                clr[g*GW +: GW] = wdata;
        end
    end

    // Mask storage; no-mask sources stay at zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dmask <= ~NOMASK_CFG;
            mmask <= ~NOMASK_CFG;
        end else if (wr_en) begin
            for (int g = 0; g < GROUPS; g++) begin
                if (grp == GSEL_W'(g)) begin
                    if (kind == KIND_DMSK) dmask[g*GW +: GW] <= wdata & ~NOMASK_CFG[g*GW +: GW];
                    if (kind == KIND_MMSK) mmask[g*GW +: GW] <= wdata & ~NOMASK_CFG[g*GW +: GW];
                end
            end
        end
    end

    // Registered readback of the addressed word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (kind)
                KIND_PEND: rdata <= pend[grp*GW +: GW];
                KIND_DMSK: rdata <= dmask[grp*GW +: GW];
                KIND_MMSK: rdata <= mmask[grp*GW +: GW];
                default:   rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_rollup.sv
// Reduces the pending image to a summary line and a critical line, both
// registered. Assumes mask bit 1 blocks delivery.
module irq_rollup #(
    parameter int              NSRC     = 128,
    parameter logic [NSRC-1:0] CRIT_CFG = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] dmask,
    output logic            summary_irq,
    output logic            crit_irq
);

    logic [NSRC-1:0] live;

    // Pending bits allowed through their mask
    always_comb live = pend & ~dmask;

    // Registered split between ordinary and critical sources
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            summary_irq <= 1'b0;
            crit_irq    <= 1'b0;
        end else begin
            summary_irq <= |(live & ~CRIT_CFG);
            crit_irq    <= |(live & CRIT_CFG);
        end
    end

endmodule

// File: rtl/irq_apex_agg.sv
// Top of the grouped interrupt aggregator: one latch per group, the register
// port and the output rollup. Assumes all inputs share clk.
module irq_apex_agg
    import irq_apex_pkg::*;
#(
    parameter int                     GROUPS     = DEF_GROUPS,
    parameter int                     GW         = DEF_GW,
    parameter logic [GROUPS*GW-1:0]   EDGE_CFG   = DEF_EDGE_CFG,
    parameter logic [GROUPS*GW-1:0]   CRIT_CFG   = DEF_CRIT_CFG,
    parameter logic [GROUPS*GW-1:0]   NOMASK_CFG = DEF_NOMASK_CFG,
    localparam int                    NSRC       = GROUPS * GW,
    localparam int                    AW         = ((GROUPS > 1) ? $clog2(GROUPS) : 1) + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_in,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [AW-1:0]   addr,
    input  logic [GW-1:0]   wdata,
    output logic [GW-1:0]   rdata,
    output logic            summary_irq,
    output logic            crit_irq
);

    logic [NSRC-1:0] pend_img;
    logic [NSRC-1:0] clr_vec;
    logic [NSRC-1:0] dmask;
    logic [NSRC-1:0] mmask;

    // One latch per group
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        irq_grp_latch #(
            .GW       (GW),
            .EDGE_CFG (EDGE_CFG[g*GW +: GW])
        ) u_latch (
            .clk   (clk),
            .rst_n (rst_n),
            .src   (irq_in[g*GW +: GW]),
            .clr   (clr_vec[g*GW +: GW]),
            .pend  (pend_img[g*GW +: GW])
        );
    end

    irq_reg_port #(
        .GROUPS     (GROUPS),
        .GW         (GW),
        .NOMASK_CFG (NOMASK_CFG)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .pend  (pend_img),
        .clr   (clr_vec),
        .dmask (dmask),
        .mmask (mmask),
        .rdata (rdata)
    );

    irq_rollup #(
        .NSRC     (NSRC),
        .CRIT_CFG (CRIT_CFG)
    ) u_roll (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend        (pend_img),
        .dmask       (dmask),
        .summary_irq (summary_irq),
        .crit_irq    (crit_irq)
    );

endmodule

// File: rtl/irq_apex_agg_chk.sv
// Property checker for the aggregator, bound to every instance of the top.
// Rebuilds clear strobes from the port and counts cycles since reset.
module irq_apex_agg_chk #(
    parameter int              GROUPS     = 4,
    parameter int              GW         = 32,
    parameter logic [GROUPS*GW-1:0] EDGE_CFG   = '0,
    parameter logic [GROUPS*GW-1:0] CRIT_CFG   = '0,
    parameter logic [GROUPS*GW-1:0] NOMASK_CFG = '0,
    localparam int             NSRC       = GROUPS * GW,
    localparam int             GSEL_W     = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int             AW         = GSEL_W + 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NSRC-1:0] irq_in,
    input logic            wr_en,
    input logic            rd_en,
    input logic [AW-1:0]   addr,
    input logic [GW-1:0]   wdata,
    input logic [GW-1:0]   rdata,
    input logic            summary_irq,
    input logic            crit_irq,
    input logic [NSRC-1:0] pend_img,
    input logic [NSRC-1:0] dmask
);

    logic [1:0]      live_cyc;
    logic [NSRC-1:0] clr_seen;

    // Cycles since reset release, saturating
    always_ff @(posedge clk) begin
        if (!rst_n)             live_cyc <= '0;
        else if (live_cyc != 2'd3) live_cyc <= live_cyc + 2'd1;
    end

    // Clear strobes as seen on the port
    always_comb begin
        clr_seen = '0;
        for (int g = 0; g < GROUPS; g++) begin
            if (wr_en && addr[AW-1 -: 2] == 2'd1 && addr[GSEL_W-1:0] == GSEL_W'(g))
                clr_seen[g*GW +: GW] = wdata;
        end
    end

    p_level_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cyc >= 2'd2) |-> (((pend_img ^ $past(irq_in, 2)) & ~EDGE_CFG) == '0));

    p_edge_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cyc >= 2'd1) |-> ((($past(pend_img) & EDGE_CFG & ~$past(clr_seen)) & ~pend_img) == '0));

    p_summary_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        summary_irq |-> $past(|(pend_img & ~dmask & ~CRIT_CFG)));

    p_crit_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        crit_irq |-> $past(|(pend_img & ~dmask & CRIT_CFG)));

    p_mask_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cyc == 2'd1 && !$past(wr_en)) |-> (dmask == ~NOMASK_CFG));

    p_clr_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (live_cyc >= 2'd1 && $past(rd_en) && $past(addr[AW-1 -: 2]) == 2'd1) |-> (rdata == '0));

endmodule

bind irq_apex_agg irq_apex_agg_chk #(
    .GROUPS     (GROUPS),
    .GW         (GW),
    .EDGE_CFG   (EDGE_CFG),
    .CRIT_CFG   (CRIT_CFG),
    .NOMASK_CFG (NOMASK_CFG)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_in      (irq_in),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .summary_irq (summary_irq),
    .crit_irq    (crit_irq),
    .pend_img    (pend_img),
    .dmask       (dmask)
);

// File: tb/irq_apex_agg_test.sv
// Directed bench for the grouped interrupt aggregator.
module irq_apex_agg_test;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] irq_in = '0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [3:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic         summary_irq;
    logic         crit_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_apex_agg uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_in      (irq_in),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .summary_irq (summary_irq),
        .crit_irq    (crit_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] kind, input logic [1:0] grp, input logic [31:0] d);
        wr_en = 1'b1; addr = {kind, grp}; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] kind, input logic [1:0] grp, output logic [31:0] d);
        rd_en = 1'b1; addr = {kind, grp};
        @(negedge clk);
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R10 summary after reset", {31'd0, summary_irq}, 32'd0);
        chk("R10 crit after reset", {31'd0, crit_irq}, 32'd0);
        for (int g = 0; g < 4; g++) begin
            rd(2'd0, 2'(g), d);
            chk("R10 pending after reset", d, 32'd0);
        end
        rd(2'd2, 2'd0, d); chk("R7 dmask reset g0", d, 32'hFFFF_FFFF);
        rd(2'd2, 2'd1, d); chk("R7 dmask reset g1", d, 32'h0003_FFFF);
        rd(2'd3, 2'd1, d); chk("R7 mmask reset g1", d, 32'h0003_FFFF);
        for (int g = 0; g < 4; g++) wr(2'd2, 2'(g), 32'd0);
    endtask

    task automatic t_level();
        logic [31:0] d;
        irq_in[5] = 1'b1;
        step(2);
        chk("R9 summary not yet", {31'd0, summary_irq}, 32'd0);
        rd(2'd0, 2'd0, d);
        chk("R1 R2 level pending g0", d, 32'h0000_0020);
        chk("R5 R9 summary from level", {31'd0, summary_irq}, 32'd1);
        wr(2'd1, 2'd0, 32'h0000_0020);
        step(1);
        rd(2'd0, 2'd0, d);
        chk("R2 level ignores clear", d, 32'h0000_0020);
        irq_in[5] = 1'b0;
        step(3);
        rd(2'd0, 2'd0, d);
        chk("R2 level drops", d, 32'd0);
        chk("R5 summary drops", {31'd0, summary_irq}, 32'd0);
    endtask

    task automatic t_crit();
        logic [31:0] d;
        irq_in[77] = 1'b1;
        step(3);
        rd(2'd0, 2'd2, d);
        chk("R1 mapping input 77", d, 32'h0000_2000);
        chk("R6 crit from critical source", {31'd0, crit_irq}, 32'd1);
        chk("R5 critical bypasses summary", {31'd0, summary_irq}, 32'd0);
        irq_in[77] = 1'b0;
        step(3);
        chk("R6 crit drops", {31'd0, crit_irq}, 32'd0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        irq_in[110] = 1'b1;
        step(1);
        irq_in[110] = 1'b0;
        step(3);
        rd(2'd0, 2'd3, d);
        chk("R3 edge pending held", d, 32'h0000_4000);
        chk("R3 summary from edge", {31'd0, summary_irq}, 32'd1);
        wr(2'd1, 2'd3, 32'h0000_4000);
        rd(2'd0, 2'd3, d);
        chk("R3 edge cleared", d, 32'd0);
        step(1);
        chk("R3 summary after clear", {31'd0, summary_irq}, 32'd0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        irq_in[110] = 1'b1;
        step(1);
        irq_in[110] = 1'b0;
        wr(2'd1, 2'd3, 32'h0000_4000);
        rd(2'd0, 2'd3, d);
        chk("R4 rise beats clear", d, 32'h0000_4000);
        wr(2'd1, 2'd3, 32'h0000_4000);
        rd(2'd0, 2'd3, d);
        chk("R4 later clear works", d, 32'd0);
        step(2);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        wr(2'd2, 2'd0, 32'h0000_0020);
        wr(2'd2, 2'd2, 32'h0000_2000);
        irq_in[5] = 1'b1;
        irq_in[77] = 1'b1;
        step(3);
        chk("R5 masked summary", {31'd0, summary_irq}, 32'd0);
        chk("R6 masked crit", {31'd0, crit_irq}, 32'd0);
        rd(2'd0, 2'd0, d);
        chk("R5 mask leaves pending", d, 32'h0000_0020);
        irq_in[5] = 1'b0;
        irq_in[77] = 1'b0;
        step(3);
    endtask

    task automatic t_nomask();
        logic [31:0] d;
        wr(2'd2, 2'd1, 32'hFFFF_FFFF);
        rd(2'd2, 2'd1, d);
        chk("R7 no-mask bits read zero", d, 32'h0003_FFFF);
        irq_in[55] = 1'b1;
        step(3);
        chk("R7 no-mask source reaches summary", {31'd0, summary_irq}, 32'd1);
        irq_in[55] = 1'b0;
        step(3);
        chk("R7 summary drops", {31'd0, summary_irq}, 32'd0);
    endtask

    task automatic t_regmap();
        logic [31:0] d;
        wr(2'd3, 2'd0, 32'hA5A5_A5A5);
        rd(2'd3, 2'd0, d);
        chk("R8 mmask readback", d, 32'hA5A5_A5A5);
        wr(2'd3, 2'd1, 32'hFFFF_FFFF);
        rd(2'd3, 2'd1, d);
        chk("R8 R7 mmask no-mask bits", d, 32'h0003_FFFF);
        wr(2'd0, 2'd0, 32'hFFFF_FFFF);
        rd(2'd0, 2'd0, d);
        chk("R8 pending word read-only", d, 32'd0);
        irq_in[3] = 1'b1;
        step(2);
        rd(2'd1, 2'd0, d);
        chk("R8 clear word reads zero", d, 32'd0);
        irq_in[3] = 1'b0;
        step(2);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_level();
        t_crit();
        t_edge();
        t_collide();
        t_mask();
        t_nomask();
        t_regmap();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule